// File: doc/BRIEF.md
# Posted-CAS DRAM Command Timing Unit

This block follows the command stream of a four-bank double-data-rate memory device and decides, clock by clock, whether each command is legal. It accepts at most one command per clock. Read and write commands are posted: they are taken in when presented but act only after a programmable additive delay. This lets a controller place a column command on the clock right after its row activate without waiting for the row-to-column delay on the command bus.

For every accepted read it raises a read-valid strobe for the two clocks that a four-beat burst occupies on the data bus. For every accepted write it raises a write-capture strobe one clock earlier than a read would. It keeps each bank in one of three states (idle, open, closing) with its own timing counters. It supports explicit and automatic precharge. Any command that targets a bank in the wrong state, or that comes too early, is dropped and reported on the following clock as a one-cycle violation pulse with a code.

Timing values are held in a configuration register. A mode-load command writes that register, and only while every bank is idle.

Top module: `dram_cmd_timer`

## Requirements
- R1: After reset all banks are idle (`bank_open` and `bank_prech` zero), both strobes and `viol` are low, and the timing set is CAS latency 3, additive delay 0, row-to-column 3, row-active minimum 6, precharge time 3, write recovery 2.
- R2: Opcode 7 (mode load) takes its fields from `cmd_cfg`: [3:0] CAS latency in half clocks, [6:4] additive delay, [9:7] row-to-column, [13:10] row-active minimum, [16:14] precharge time, [19:17] write recovery. It is accepted only if every bank is idle (not open, not closing) and the half-clock CAS value is 6, 8 or 10, the additive delay is 0..4, row-to-column is 2..5, row-active is 5..15, precharge is 2..5 and write recovery is 2..4. Otherwise it yields code 6 and the timing set is unchanged.
- R3: Opcodes are 0 no-op, 1 activate, 2 read, 3 write, 4 read with auto-precharge, 5 write with auto-precharge, 6 precharge. A rejected command produces `viol` high for exactly the next clock with `viol_code` holding the rule (1 bank not open, 2 bank not idle, 3 row-to-column, 4 row-active minimum, 5 data/recovery before precharge, 6 mode load, 7 auto-precharge pending), and it has no effect.
- R4: A column command issued k clocks after the activate of its bank is legal when k plus the additive delay is at least the row-to-column value, else code 3.
- R5: `rd_valid` is high during clocks c+AL+CL and c+AL+CL+1 for a read accepted in clock c.
- R6: `wr_capture` is high during clocks c+AL+CL-1 and c+AL+CL for a write accepted in clock c.
- R7: A precharge k clocks after activate needs k at least the row-active minimum (else code 4). After a column command it needs at least AL+2 clocks (read) or AL+CL+1+tWR clocks (write) (else code 5).
- R8: A precharge in clock p sets the bank closing for clocks p+1 .. p+tRP-1 and idle from p+tRP. An activate before then gets code 2. A precharge to a bank that is idle or closing does nothing and is not a violation.
- R9: An auto-precharge command in clock c starts the close at the later of c plus the precharge delay of R7 and the activate plus the row-active minimum. Until the close starts, any command to that bank gets code 7.
- R10: An activate to a bank that is open or closing gets code 2. A column command to a bank that is not open gets code 1.
- R11: Bank state and counters are independent; a command to one bank never changes another.
- R12: Column commands on back-to-back clocks give strobe pulses that overlap into one continuous run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_op | input | 3 | Command opcode (R3) |
| cmd_bank | input | 2 | Target bank |
| cmd_cfg | input | 20 | Mode-load fields (R2) |
| viol | output | 1 | One-cycle rejection pulse |
| viol_code | output | 3 | Rule broken by the rejected command |
| rd_valid | output | 1 | Read data on the bus this clock |
| wr_capture | output | 1 | Write data must be captured this clock |
| bank_open | output | 4 | Per-bank open (active) state |
| bank_prech | output | 4 | Per-bank closing (precharging) state |

## Verification
A wrong bank state or counter shows at the ports within one clock of the next command to that bank. The command is either rejected with an unexpected code or accepted where a code was due, and a missed or early close shows directly on `bank_open` and `bank_prech`. A wrong latency or a corrupted timing register appears as a strobe run shifted by one or more clocks, which the bench sees as a bit mask of the strobes over a fixed window after each column command. The sweep crosses every legal CAS latency and additive delay with every row-to-column value and every issue distance up to that value, so an off-by-one in the posted-delay comparison cannot hide.

// File: rtl/dct_pkg.sv
package dct_pkg;

  localparam int CFG_W = 20;

  typedef enum logic [2:0] {
    OP_NOP, OP_ACT, OP_RD, OP_WR, OP_RDA, OP_WRA, OP_PRE, OP_MRS
  } op_e;

  typedef enum logic [2:0] {
    V_NONE, V_NOT_OPEN, V_NOT_IDLE, V_RCD, V_RAS, V_RECOV, V_CFG, V_BUSY
  } viol_e;

  typedef enum logic [1:0] {
    BK_IDLE, BK_ACTIVE, BK_PRECH
  } bank_st_e;

  typedef struct packed {
    logic [2:0] twr;
    logic [2:0] trp;
    logic [3:0] tras;
    logic [2:0] trcd;
    logic [2:0] al;
    logic [3:0] cl_half;
  } cfg_t;

  function automatic logic cfg_legal(input cfg_t c);
    logic ok;
    ok = (c.cl_half == 4'd6) || (c.cl_half == 4'd8) || (c.cl_half == 4'd10);
    ok = ok && (c.al <= 3'd4);
    ok = ok && (c.trcd >= 3'd2) && (c.trcd <= 3'd5);
    ok = ok && (c.tras >= 4'd5);
    ok = ok && (c.trp >= 3'd2) && (c.trp <= 3'd5);
    ok = ok && (c.twr >= 3'd2) && (c.twr <= 3'd4);
    return ok;
  endfunction

endpackage

// File: rtl/dct_bank.sv
module dct_bank
  import dct_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             do_act,
  input  logic             do_pre,
  input  logic             do_col,
  input  logic             col_ap,
  input  logic [CNT_W-1:0] col_hold,
  input  logic [CNT_W-1:0] trcd_m1,
  input  logic [CNT_W-1:0] tras_m1,
  input  logic [CNT_W-1:0] trp_m1,
  output logic             is_idle,
  output logic             is_active,
  output logic             is_prech,
  output logic [CNT_W-1:0] rcd_left,
  output logic             ras_ok,
  output logic             col_ok,
  output logic             ap_pend
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  bank_st_e         st;
  logic [CNT_W-1:0] rcd_cnt, ras_cnt, col_cnt, rp_cnt;
  logic             ap_q;
  logic             auto_fire;
  logic             close_now;
  logic [CNT_W-1:0] col_dec;

  assign auto_fire = ap_q && (st == BK_ACTIVE) && (col_cnt == '0) && (ras_cnt == '0);
  assign close_now = do_pre || auto_fire;
  assign col_dec   = (col_cnt == '0) ? '0 : col_cnt - ONE;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= BK_IDLE;
      rcd_cnt <= '0;
      ras_cnt <= '0;
      col_cnt <= '0;
      rp_cnt  <= '0;
      ap_q    <= 1'b0;
    end else begin
      if (do_act) begin
        rcd_cnt <= trcd_m1;
        ras_cnt <= tras_m1;
      end else begin
        if (rcd_cnt != '0) rcd_cnt <= rcd_cnt - ONE;
        if (ras_cnt != '0) ras_cnt <= ras_cnt - ONE;
      end

      if (do_col) col_cnt <= (col_hold > col_dec) ? col_hold : col_dec;
      else        col_cnt <= col_dec;

      if (close_now)           ap_q <= 1'b0;
      else if (do_col && col_ap) ap_q <= 1'b1;

      if (do_act) begin
        st <= BK_ACTIVE;
      end else if (close_now) begin
        st     <= BK_PRECH;
        rp_cnt <= trp_m1;
      end else if (st == BK_PRECH) begin
        if (rp_cnt <= ONE) begin
          st     <= BK_IDLE;
          rp_cnt <= '0;
        end else begin
          rp_cnt <= rp_cnt - ONE;
        end
      end
    end
  end

  assign is_idle   = (st == BK_IDLE);
  assign is_active = (st == BK_ACTIVE);
  assign is_prech  = (st == BK_PRECH);
  assign rcd_left  = rcd_cnt;
  assign ras_ok    = (ras_cnt == '0);
  assign col_ok    = (col_cnt == '0);
  assign ap_pend   = ap_q;

  p_act_only_idle_r10: assert property (@(posedge clk) disable iff (rst)
    do_act |-> st == BK_IDLE);
  p_col_only_open_r9: assert property (@(posedge clk) disable iff (rst)
    do_col |-> (st == BK_ACTIVE) && !ap_q);
  p_pre_timing_r7: assert property (@(posedge clk) disable iff (rst)
    do_pre |-> (st == BK_ACTIVE) && (ras_cnt == '0) && (col_cnt == '0));
  p_prech_counts_r8: assert property (@(posedge clk) disable iff (rst)
    (st == BK_PRECH) |-> rp_cnt != '0);
  p_ap_ends_in_close_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(ap_q) |-> st == BK_PRECH);

endmodule

// File: rtl/dct_strobe.sv
module dct_strobe #(
  parameter int W     = 10,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fire,
  input  logic [CNT_W-1:0] lat,
  output logic             strobe
);

  logic [W-1:0] sched;
  logic [W-1:0] ins;

  assign ins = fire ? (W'(3) << (lat - CNT_W'(1))) : '0;

  always_ff @(posedge clk) begin
    if (rst) sched <= '0;
    else     sched <= (sched >> 1) | ins;
  end

  assign strobe = sched[0];

  p_burst_two_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(strobe) |=> strobe);

endmodule

// File: rtl/dram_cmd_timer.sv
module dram_cmd_timer
  import dct_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int MAX_LAT   = 9,
  parameter int CNT_W     = 4,
  parameter int DEF_CL    = 3,
  parameter int DEF_AL    = 0,
  parameter int DEF_TRCD  = 3,
  parameter int DEF_TRAS  = 6,
  parameter int DEF_TRP   = 3,
  parameter int DEF_TWR   = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [2:0]           cmd_op,
  input  logic [1:0]           cmd_bank,
  input  logic [CFG_W-1:0]     cmd_cfg,
  output logic                 viol,
  output logic [2:0]           viol_code,
  output logic                 rd_valid,
  output logic                 wr_capture,
  output logic [NUM_BANKS-1:0] bank_open,
  output logic [NUM_BANKS-1:0] bank_prech
);

  localparam int PIPE_W = MAX_LAT + 1;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  op_e              op;
  cfg_t             cw;
  logic [CNT_W-1:0] cl_q, al_q, trcd_q, tras_q, trp_q, twr_q;
  logic [CNT_W-1:0] rl, col_hold;
  logic             rd_op, wr_op, col_op, ap_op, acc;
  viol_e            code;

  logic [NUM_BANKS-1:0] bk_idle, bk_act, bk_prech, bk_ras_ok, bk_col_ok, bk_ap;
  logic [CNT_W-1:0]     bk_rcd [NUM_BANKS];

  assign op       = op_e'(cmd_op);
  assign cw       = cmd_cfg;
  assign rd_op    = (op == OP_RD) || (op == OP_RDA);
  assign wr_op    = (op == OP_WR) || (op == OP_WRA);
  assign col_op   = rd_op || wr_op;
  assign ap_op    = (op == OP_RDA) || (op == OP_WRA);
  assign rl       = cl_q + al_q;
  assign col_hold = wr_op ? (rl + twr_q) : (al_q + ONE);

  always_comb begin
    code = V_NONE;
    case (op)
      OP_ACT: begin
        if (bk_ap[cmd_bank])        code = V_BUSY;
        else if (!bk_idle[cmd_bank]) code = V_NOT_IDLE;
      end
      OP_RD, OP_WR, OP_RDA, OP_WRA: begin
        if (bk_ap[cmd_bank])                code = V_BUSY;
        else if (!bk_act[cmd_bank])          code = V_NOT_OPEN;
        else if (bk_rcd[cmd_bank] > al_q)    code = V_RCD;
      end
      OP_PRE: begin
        if (bk_ap[cmd_bank]) code = V_BUSY;
        else if (bk_act[cmd_bank]) begin
          if (!bk_ras_ok[cmd_bank])      code = V_RAS;
          else if (!bk_col_ok[cmd_bank]) code = V_RECOV;
        end
      end
      OP_MRS: begin
        if (!(&bk_idle) || !cfg_legal(cw)) code = V_CFG;
      end
      default: code = V_NONE;
    endcase
  end

  assign acc = (code == V_NONE);

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    logic hit;
    assign hit = (cmd_bank == 2'(g));
    dct_bank #(.CNT_W(CNT_W)) u_bank (
      .clk      (clk),
      .rst      (rst),
      .do_act   (acc && (op == OP_ACT) && hit),
      .do_pre   (acc && (op == OP_PRE) && hit && bk_act[g]),
      .do_col   (acc && col_op && hit),
      .col_ap   (ap_op),
      .col_hold (col_hold),
      .trcd_m1  (trcd_q - ONE),
      .tras_m1  (tras_q - ONE),
      .trp_m1   (trp_q - ONE),
      .is_idle  (bk_idle[g]),
      .is_active(bk_act[g]),
      .is_prech (bk_prech[g]),
      .rcd_left (bk_rcd[g]),
      .ras_ok   (bk_ras_ok[g]),
      .col_ok   (bk_col_ok[g]),
      .ap_pend  (bk_ap[g])
    );
  end

  dct_strobe #(.W(PIPE_W), .CNT_W(CNT_W)) u_rd_pipe (
    .clk(clk), .rst(rst), .fire(acc && rd_op), .lat(rl), .strobe(rd_valid));

  dct_strobe #(.W(PIPE_W), .CNT_W(CNT_W)) u_wr_pipe (
    .clk(clk), .rst(rst), .fire(acc && wr_op), .lat(rl - ONE), .strobe(wr_capture));

  always_ff @(posedge clk) begin
    if (rst) begin
      cl_q      <= CNT_W'(DEF_CL);
      al_q      <= CNT_W'(DEF_AL);
      trcd_q    <= CNT_W'(DEF_TRCD);
      tras_q    <= CNT_W'(DEF_TRAS);
      trp_q     <= CNT_W'(DEF_TRP);
      twr_q     <= CNT_W'(DEF_TWR);
      viol      <= 1'b0;
      viol_code <= V_NONE;
    end else begin
      viol      <= !acc;
      viol_code <= code;
      if (acc && (op == OP_MRS)) begin
        cl_q   <= CNT_W'(cw.cl_half >> 1);
        al_q   <= CNT_W'(cw.al);
        trcd_q <= CNT_W'(cw.trcd);
        tras_q <= CNT_W'(cw.tras);
        trp_q  <= CNT_W'(cw.trp);
        twr_q  <= CNT_W'(cw.twr);
      end
    end
  end

  assign bank_open  = bk_act;
  assign bank_prech = bk_prech;

  p_viol_has_code_r3: assert property (@(posedge clk) disable iff (rst)
    viol |-> viol_code != V_NONE);
  p_cfg_in_range_r2: assert property (@(posedge clk) disable iff (rst)
    (cl_q >= CNT_W'(3)) && (cl_q <= CNT_W'(5)) && (al_q <= CNT_W'(4)));
  p_no_cfg_while_busy_r2: assert property (@(posedge clk) disable iff (rst)
    !(&bk_idle) |=> $stable(cl_q) && $stable(tras_q));

endmodule

// File: tb/dram_cmd_timer_test.sv
`timescale 1ns/1ps
module dram_cmd_timer_test;

  localparam int NOP = 0, ACT = 1, RD = 2, WR = 3, RDA = 4, WRA = 5, PRE = 6, MRS = 7;

  logic        clk = 1'b0;
  logic        rst;
  logic [2:0]  cmd_op;
  logic [1:0]  cmd_bank;
  logic [19:0] cmd_cfg;
  logic        viol, rd_valid, wr_capture;
  logic [2:0]  viol_code;
  logic [3:0]  bank_open, bank_prech;

  int checks = 0;
  int errors = 0;

  dram_cmd_timer uut (
    .clk(clk), .rst(rst), .cmd_op(cmd_op), .cmd_bank(cmd_bank), .cmd_cfg(cmd_cfg),
    .viol(viol), .viol_code(viol_code), .rd_valid(rd_valid), .wr_capture(wr_capture),
    .bank_open(bank_open), .bank_prech(bank_prech));

  always #2.5 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic report;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic step(input int op, input int bk);
    cmd_op   = 3'(op);
    cmd_bank = 2'(bk);
    @(posedge clk);
    @(negedge clk);
    cmd_op = 3'(NOP);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(NOP, 0);
  endtask

  task automatic mrs(input int clh, input int al, input int trcd, input int tras,
                     input int trp, input int twr);
    cmd_cfg = {3'(twr), 3'(trp), 4'(tras), 3'(trcd), 3'(al), 4'(clh)};
    step(MRS, 0);
  endtask

  // m = 1 is the clock right after the command just issued
  task automatic watch(input int n, input int bk, output logic [15:0] rm,
                       output logic [15:0] wm, output logic [15:0] pm);
    rm = '0; wm = '0; pm = '0;
    for (int m = 1; m <= n; m++) begin
      if (m > 1) step(NOP, 0);
      rm[m] = rd_valid;
      wm[m] = wr_capture;
      pm[m] = bank_prech[bk];
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    report();
  end

  initial begin
    logic [15:0] rm, wm, pm;
    rst = 1'b1; cmd_op = 3'(NOP); cmd_bank = '0; cmd_cfg = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state and default timing
    chk("R1 bank_open", int'(bank_open), 0);
    chk("R1 bank_prech", int'(bank_prech), 0);
    chk("R1 strobes", int'({rd_valid, wr_capture, viol}), 0);
    step(ACT, 0);
    step(RD, 0);  chk("R1 R4 default tRCD k=1", int'(viol_code), 3);
    step(RD, 0);  chk("R1 R4 default tRCD k=2", int'(viol_code), 3);
    step(RD, 0);  chk("R1 R4 default tRCD k=3", int'(viol_code), 0);
    watch(12, 0, rm, wm, pm);
    chk("R1 R5 default read latency", int'(rm), 16'h0018);
    step(PRE, 0); idle(3);

    // R10 wrong bank state, R3 pulse width
    step(RD, 3);  chk("R10 read closed bank", int'(viol_code), 1);
    chk("R3 viol pulse", int'(viol), 1);
    step(ACT, 0);
    step(ACT, 0); chk("R10 activate open bank", int'(viol_code), 2);
    step(NOP, 0); chk("R3 viol one cycle", int'(viol), 0);
    idle(4);
    step(PRE, 0); chk("R7 precharge at tRAS", int'(viol_code), 0);
    idle(3);

    // R11 bank independence
    step(ACT, 0);
    step(ACT, 1);
    step(NOP, 0);
    step(RD, 1);  chk("R11 bank1 own tRCD", int'(viol_code), 3);
    step(RD, 0);  chk("R11 bank0 ready", int'(viol_code), 0);
    idle(8);
    step(PRE, 0); chk("R11 pre bank0", int'(viol_code), 0);
    chk("R11 bank1 stays open", int'(bank_open), 2);
    step(PRE, 1); idle(3);
    chk("R11 all closed", int'(bank_open), 0);

    // R12 back-to-back reads overlap
    step(ACT, 2); idle(2);
    step(RD, 2);
    step(RD, 2);  chk("R12 second read accepted", int'(viol_code), 0);
    watch(8, 2, rm, wm, pm);
    chk("R12 merged strobe run", int'(rm), 16'h001C);
    step(PRE, 2); idle(3);

    // R7 R8 row-active minimum, precharge window
    step(ACT, 1); idle(4);
    step(PRE, 1); chk("R7 precharge before tRAS", int'(viol_code), 4);
    step(PRE, 1); chk("R7 precharge at tRAS", int'(viol_code), 0);
    chk("R8 closing after pre", int'({bank_open[1], bank_prech[1]}), 1);
    step(ACT, 1); chk("R8 activate while closing", int'(viol_code), 2);
    chk("R8 still closing p+2", int'(bank_prech[1]), 1);
    step(NOP, 0); chk("R8 idle at p+tRP", int'(bank_prech[1]), 0);
    step(ACT, 1); chk("R8 activate after tRP", int'(viol_code), 0);
    chk("R8 open again", int'(bank_open[1]), 1);
    idle(5);
    step(WR, 1);  chk("R7 write accepted", int'(viol_code), 0);
    idle(4);
    step(PRE, 1); chk("R7 write recovery early", int'(viol_code), 5);
    step(PRE, 1); chk("R7 write recovery met", int'(viol_code), 0);
    idle(3);
    step(PRE, 3); chk("R8 pre to idle bank ignored", int'(viol_code), 0);
    chk("R8 idle bank untouched", int'({bank_open, bank_prech}), 0);

    // R9 auto-precharge
    step(ACT, 2); idle(2);
    step(RDA, 2); chk("R9 read auto-pre accepted", int'(viol_code), 0);
    watch(8, 2, rm, wm, pm);
    chk("R9 read auto-pre close window", int'(pm), 16'h0030);
    chk("R9 R5 read data", int'(rm), 16'h0018);
    step(ACT, 3); idle(2);
    step(WRA, 3);
    watch(12, 3, rm, wm, pm);
    chk("R9 write auto-pre close window", int'(pm), 16'h0180);
    chk("R9 R6 write capture", int'(wm), 16'h000C);
    step(ACT, 0); idle(2);
    step(WRA, 0);
    step(PRE, 0); chk("R9 pre while pending", int'(viol_code), 7);
    step(ACT, 0); chk("R9 act while pending", int'(viol_code), 7);
    step(RD, 0);  chk("R9 read while pending", int'(viol_code), 7);
    idle(12);
    chk("R9 bank closed itself", int'({bank_open, bank_prech}), 0);

    // R2 mode load rules
    mrs(7, 0, 5, 6, 3, 2);   chk("R2 half-cycle CAS rejected", int'(viol_code), 6);
    mrs(10, 0, 5, 4, 3, 2);  chk("R2 tRAS below range", int'(viol_code), 6);
    step(ACT, 0);
    mrs(10, 0, 5, 6, 3, 2);  chk("R2 load with bank open", int'(viol_code), 6);
    idle(6); step(PRE, 0); idle(3);
    step(ACT, 1); idle(2);
    step(RD, 1);  chk("R2 timing unchanged tRCD", int'(viol_code), 0);
    watch(10, 1, rm, wm, pm);
    chk("R2 timing unchanged latency", int'(rm), 16'h0018);
    step(PRE, 1); idle(3);

    // Sweep: R4 R5 R6 over all CAS latencies, additive delays, tRCD values
    for (int cl = 3; cl <= 5; cl++) begin
      for (int al = 0; al <= 4; al++) begin
        for (int trcd = 2; trcd <= 5; trcd++) begin
          mrs(2 * cl, al, trcd, 5, 2, 2);
          chk("R2 legal load", int'(viol_code), 0);
          for (int k = 1; k <= trcd; k++) begin
            int  bk;
            int  rl;
            bit  legal;
            bit  is_rd;
            bk    = k % 4;
            rl    = al + cl;
            legal = (k + al >= trcd);
            is_rd = (k % 2 == 1);
            step(ACT, bk);
            idle(k - 1);
            step(is_rd ? RD : WR, bk);
            chk("R4 posted tRCD", int'(viol_code), legal ? 0 : 3);
            watch(14, bk, rm, wm, pm);
            chk("R5 read strobe", int'(rm), (legal && is_rd) ? (3 << rl) : 0);
            chk("R6 write strobe", int'(wm), (legal && !is_rd) ? (3 << (rl - 1)) : 0);
            step(PRE, bk);
            chk("R7 pre after burst", int'(viol_code), 0);
            idle(2);
          end
        end
      end
    end

    report();
  end

endmodule